// File: doc/BRIEF.md
# I2C Serial Memory Read Slave

This block is the I2C slave side of a small on-chip byte memory. It watches open-drain SCL and SDA, recognises its own slave address byte, and takes a two-byte word address in a write phase. It returns memory bytes in three kinds of read. A random read is a write phase followed by a repeated start and a read address byte. A current-address read needs no address phase. A sequential read keeps going for as long as the master acknowledges. A persistent address counter links these operations. A stop that comes straight after the word address only loads that counter, so a later current-address read starts there.

Both bus lines are sampled on the system clock through a synchronizer. Start and stop are found as SDA edges while SCL is high. The slave pulls SDA low by raising `sda_oe_o`. The memory array sits behind a plain read port. `mem_addr_o` always shows the counter. `mem_rdata_i` must hold the byte at that address within two system clocks of any address change.

Top module: `i2c_rd_slave`

## Requirements
- R1: The slave acknowledges an address byte only when bits 7:4 are 1010, bits 3:2 equal `sel_i`, and bit 1 is 0. Bit 0 is R/W, with 1 meaning read. Any other address byte gets no ACK, and the slave then ignores the bus until the next start.
- R2: After a matching address byte with R/W=0, the slave acknowledges two word-address bytes, high byte first.
- R3: When the second word-address ACK is followed by a repeated start and a matching read address byte, the slave returns the byte stored at the loaded address.
- R4: The counter is loaded with the word address when the second word-address ACK completes. A stop at that point therefore loads the counter and transfers no data.
- R5: A read address byte with no address phase before it returns data from the current counter value, including a value set by R4.
- R6: Each master ACK after a data byte makes the slave send the byte at the next address.
- R7: The counter wraps from DEPTH-1 to 0. Word-address bits above the memory depth are dropped.
- R8: After a master NACK the slave releases SDA and drives nothing until a new start.
- R9: After a stop, bus activity is ignored until a start is seen.
- R10: After every byte sent, the counter points one past the address of that byte.
- R11: After reset, SDA is released and the counter is 0.
- R12: Data goes out MSB first, and the slave changes SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sel_i | input | 2 | Strap values compared with address bits 3:2 |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| mem_addr_o | output | $clog2(DEPTH) | Address counter, read address of the array |
| mem_rdata_i | input | 8 | Array byte at mem_addr_o |

## Verification
Every SCL edge passes through two synchronizer flops and one edge-detect register. A slave reaction to an edge therefore appears on `sda_oe_o` three system clocks after the raw SCL edge. The bench model moves SDA six clocks after each SCL fall and samples it six clocks after each SCL rise, both well after that three-cycle delay. Counter results, namely the load after the second ACK and the increment after each sent byte, are read on `mem_addr_o` once the whole bus operation has ended. A monitor runs through the whole run and flags any `sda_oe_o` change made while raw SCL is high.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WAH,
    ST_WAH_ACK,
    ST_WAL,
    ST_WAL_ACK,
    ST_HOLD,
    ST_RD,
    ST_RD_ACK
  } rd_state_e;
endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] scl_sync, sda_sync;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[STAGES-2:0], sda_i};
      scl_p    <= scl_sync[STAGES-1];
      sda_p    <= sda_sync[STAGES-1];
    end
  end

  assign scl_o   = scl_sync[STAGES-1];
  assign sda_o   = sda_sync[STAGES-1];
  assign rise_o  = scl_o & ~scl_p;
  assign fall_o  = ~scl_o & scl_p;
  assign start_o = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o  = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/i2c_addr_ctr.sv
module i2c_addr_ctr #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end

  assert_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_o == $past(load_val_i));

  assert_inc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i) |=> cnt_o == $past(cnt_o) + 1'b1);

  assert_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && cnt_o == {AW{1'b1}}) |=> cnt_o == '0);
endmodule

// File: rtl/i2c_rd_slave.sv
module i2c_rd_slave
  import i2c_rd_pkg::*;
#(
  parameter  int unsigned DEPTH       = 256,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned AW          = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [1:0]    sel_i,
  output logic          sda_oe_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_rdata_i
);
  localparam int unsigned WA_W = 16;

  logic scl_s, sda_s, start, stop, rise, fall;
  rd_state_e state_q;
  logic [3:0] cnt_q;
  logic [7:0] sr_q, wah_q;
  logic rw_q, ack_q, oe_q;
  logic ctr_load, ctr_inc, dev_hit, quiet;
  logic [WA_W-1:0] wa_full;

  i2c_bus_cond #(.STAGES(SYNC_STAGES)) u_cond (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .start_o(start), .stop_o(stop),
    .rise_o(rise), .fall_o(fall)
  );

  assign quiet    = !start && !stop;
  assign dev_hit  = sr_q[7:4] == DEV_TYPE && sr_q[3:2] == sel_i && !sr_q[1];
  assign wa_full  = {wah_q, sr_q};
  assign ctr_load = quiet && fall && state_q == ST_WAL_ACK;
  assign ctr_inc  = quiet && fall && state_q == ST_RD && cnt_q == 4'd8;

  i2c_addr_ctr #(.AW(AW)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ctr_load),
    .load_val_i(wa_full[AW-1:0]), .inc_i(ctr_inc), .cnt_o(mem_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sr_q    <= '0;
      wah_q   <= '0;
      rw_q    <= 1'b0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else if (start) begin
      state_q <= ST_DEV;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_DEV, ST_WAH, ST_WAL: begin
          if (rise && cnt_q != 4'd8) begin
            sr_q  <= {sr_q[6:0], sda_s};
            cnt_q <= cnt_q + 4'd1;
          end else if (fall && cnt_q == 4'd8) begin
            if (state_q == ST_DEV) begin
              if (dev_hit) begin
                oe_q    <= 1'b1;
                rw_q    <= sr_q[0];
                state_q <= ST_DEV_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (state_q == ST_WAH) begin
              wah_q   <= sr_q;
              oe_q    <= 1'b1;
              state_q <= ST_WAH_ACK;
            end else begin
              oe_q    <= 1'b1;
              state_q <= ST_WAL_ACK;
            end
          end
        end
        ST_DEV_ACK: if (fall) begin
          if (rw_q) begin
            sr_q    <= mem_rdata_i;
            oe_q    <= ~mem_rdata_i[7];
            cnt_q   <= 4'd1;
            state_q <= ST_RD;
          end else begin
            oe_q    <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_WAH;
          end
        end
        ST_WAH_ACK: if (fall) begin
          oe_q    <= 1'b0;
          cnt_q   <= '0;
          state_q <= ST_WAL;
        end
        ST_WAL_ACK: if (fall) begin
          oe_q    <= 1'b0;
          state_q <= ST_HOLD;
        end
        ST_RD: if (fall) begin
          if (cnt_q == 4'd8) begin
            oe_q    <= 1'b0;
            state_q <= ST_RD_ACK;
          end else begin
            sr_q  <= {sr_q[6:0], 1'b0};
            oe_q  <= ~sr_q[6];
            cnt_q <= cnt_q + 4'd1;
          end
        end
        ST_RD_ACK: begin
          if (rise) ack_q <= ~sda_s;
          else if (fall) begin
            if (ack_q) begin
              sr_q    <= mem_rdata_i;
              oe_q    <= ~mem_rdata_i[7];
              cnt_q   <= 4'd1;
              state_q <= ST_RD;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;

  // SDA moves only in SCL low, except the release forced by a bus condition
  assert_sda_in_low_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> (!scl_s || $past(start || stop)));

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE |-> !oe_q);

  assert_ack_match_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DEV_ACK |-> (sr_q[7:4] == DEV_TYPE && !sr_q[1]));

  assert_rdack_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RD_ACK |-> !oe_q);
endmodule

// File: tb/sim_i2c_rd_slave.sv
`timescale 1ns/1ps
module sim_i2c_rd_slave;
  localparam int unsigned DEPTH = 256;
  localparam int unsigned AW    = 8;
  localparam int T = 6;
  localparam int NVEC = 6;
  localparam logic [1:0] SEL = 2'b01;
  localparam logic [7:0] DEV_W = 8'hA4;
  localparam logic [7:0] DEV_R = 8'hA5;

  // {mode, word address, byte count}; mode 0 random, 1 set-current then read, 2 current
  localparam logic [27:0] VEC [NVEC] = '{
    {4'd0, 16'h0010, 8'd3},
    {4'd2, 16'h0000, 8'd2},
    {4'd1, 16'h0080, 8'd1},
    {4'd0, 16'h00FE, 8'd4},
    {4'd0, 16'h1234, 8'd2},
    {4'd2, 16'h0000, 8'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata;
  logic sda_bus;
  int checks = 0;
  int fails = 0;
  int viol = 0;
  bit done = 0;
  logic [AW-1:0] exp_ctr = '0;

  always #2.5 clk = ~clk;

  assign sda_bus   = sda_m & ~sda_oe;
  assign mem_rdata = mem_addr ^ 8'h5C;

  i2c_rd_slave #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sel_i(SEL),
    .sda_oe_o(sda_oe), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata)
  );

  // R12 monitor: slave must not move SDA while SCL is high
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && sda_oe !== oe_prev) viol++;
    oe_prev <= sda_oe;
  end

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitc(T);
    scl = 1'b1;   waitc(T);
    sda_m = 1'b0; waitc(T);
    scl = 1'b0;   waitc(T);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitc(T);
    scl = 1'b1;   waitc(T);
    sda_m = 1'b1; waitc(2*T);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; waitc(T);
      scl = 1'b1;   waitc(2*T);
      scl = 1'b0;   waitc(T);
    end
    sda_m = 1'b1; waitc(T);
    scl = 1'b1;   waitc(T);
    ack = ~sda_bus;
    waitc(T);
    scl = 1'b0;   waitc(T);
  endtask

  task automatic rd_byte(input logic ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitc(T);
      scl = 1'b1; waitc(T);
      b[i] = sda_bus;
      waitc(T);
      scl = 1'b0;
    end
    waitc(T);
    sda_m = ack ? 1'b0 : 1'b1; waitc(T);
    scl = 1'b1; waitc(2*T);
    scl = 1'b0; waitc(T);
    sda_m = 1'b1;
  endtask

  task automatic read_run(input int n, input string tag);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      rd_byte(k != n - 1, d);
      chk(tag, {24'd0, d}, {24'd0, exp_ctr ^ 8'h5C});
      exp_ctr = exp_ctr + 1'b1;
    end
  endtask

  task automatic addr_phase(input logic [15:0] wa);
    logic a;
    bus_start();
    wr_byte(DEV_W, a); chk("R1 write addr ack", {31'd0, a}, 32'd1);
    wr_byte(wa[15:8], a); chk("R2 high byte ack", {31'd0, a}, 32'd1);
    wr_byte(wa[7:0], a); chk("R2 low byte ack", {31'd0, a}, 32'd1);
    exp_ctr = wa[AW-1:0];
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    waitc(10);
    // R11 reset state
    chk("R11 oe after reset", {31'd0, sda_oe}, 32'd0);
    chk("R11 counter after reset", {24'd0, mem_addr}, 32'd0);
    rst_n = 1'b1;
    waitc(10);

    for (int v = 0; v < NVEC; v++) begin
      logic [3:0] mode;
      logic [15:0] wa;
      int n;
      mode = VEC[v][27:24];
      wa   = VEC[v][23:8];
      n    = int'(VEC[v][7:0]);
      if (mode == 4'd0) begin
        addr_phase(wa);
        bus_start();
        wr_byte(DEV_R, a); chk("R3 read addr ack", {31'd0, a}, 32'd1);
        read_run(n, "R3 R6 R7 random/sequential data");
      end else if (mode == 4'd1) begin
        addr_phase(wa);
        bus_stop();
        chk("R4 counter after set-current", {24'd0, mem_addr}, {24'd0, exp_ctr});
        bus_start();
        wr_byte(DEV_R, a); chk("R5 read addr ack", {31'd0, a}, 32'd1);
        read_run(n, "R5 data after set-current");
      end else begin
        bus_start();
        wr_byte(DEV_R, a); chk("R5 current read ack", {31'd0, a}, 32'd1);
        read_run(n, "R5 R6 current read data");
      end
      bus_stop();
      chk("R10 counter past last byte", {24'd0, mem_addr}, {24'd0, exp_ctr});
    end

    // R1 mismatching address bytes: no ACK, idle until start
    bus_start();
    wr_byte(8'hB4, a); chk("R1 wrong device type", {31'd0, a}, 32'd0);
    wr_byte(DEV_R, a); chk("R1 ignored until start", {31'd0, a}, 32'd0);
    bus_stop();
    bus_start();
    wr_byte(8'hA8, a); chk("R1 wrong select bits", {31'd0, a}, 32'd0);
    bus_stop();
    bus_start();
    wr_byte(8'hA6, a); chk("R1 bit1 set", {31'd0, a}, 32'd0);
    bus_stop();
    chk("R1 counter untouched", {24'd0, mem_addr}, {24'd0, exp_ctr});

    // R9 standby after stop
    scl = 1'b0; waitc(T);
    wr_byte(DEV_R, a); chk("R9 no ack in standby", {31'd0, a}, 32'd0);
    chk("R9 SDA released in standby", {31'd0, sda_oe}, 32'd0);
    bus_stop();

    // R8 release after NACK
    bus_start();
    wr_byte(DEV_R, a); chk("R8 read ack", {31'd0, a}, 32'd1);
    rd_byte(1'b0, d);
    chk("R8 data before nack", {24'd0, d}, {24'd0, exp_ctr ^ 8'h5C});
    exp_ctr = exp_ctr + 1'b1;
    rd_byte(1'b0, d); chk("R8 bus released after nack", {24'd0, d}, 32'hFF);
    bus_stop();
    chk("R10 counter after nack", {24'd0, mem_addr}, {24'd0, exp_ctr});

    chk("R12 SDA changes while SCL high", viol, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule